// File: doc/BRIEF.md
# Fractional-N Dual Divider Core

This block produces the two comparison pulses that feed the phase detector of a fractional-N synthesizer. One path divides a reference tick stream by one of four selectable ratios. The other path divides an RF-derived tick stream by an integer modulus N or N+1. A 2-bit accumulator chooses between the two moduli, so the long-run ratio of the RF path is N + k/4. Both input streams arrive as single-cycle clock enables in the core clock domain.

Software writes a scaling word SF = 4·N + k together with a reference-ratio code and marks the write as complete with `word_done`. The first word wakes both dividers from their held state. Later words wait in a shadow copy. A shadow word is moved into use only at a main-divider terminal count during which the charge pump reports idle, so a retune never lands in the middle of a correction pulse. When the test enable is set, two monitor taps repeat the divider pulses.

Top module: `fracn_divcore`

## Requirements
- R1: From reset until the first `word_done`, both dividers are held, and `ref_pulse`, `main_pulse`, `mon_ref` and `mon_main` stay low.
- R2: The reference path pulses once every R accepted `ref_en` ticks. R depends on `ref_sel`: code 0 selects REF_A (280), code 1 selects REF_B (288), code 2 selects REF_C (256) and code 3 selects REF_D (384).
- R3: In the scaling word, bits [SF_W-1:2] give N and bits [1:0] give k. A 2-bit accumulator starts at 0 when a word is loaded and adds k at every main terminal count. A main cycle follows a count at which the accumulator wrapped, and that cycle lasts N+1 `rf_en` ticks; every other main cycle lasts N ticks. As a result, any four consecutive main cycles take 4·N+k ticks.
- R4: A scaling word below SF_MIN is treated as SF_MIN.
- R5: Each pulse is high for exactly one clock. It is registered, so it appears in the clock after the enable edge that completes the count. Reload costs no extra tick.
- R6: The first word loads at once. The reference counter starts a full R-tick cycle and the main counter starts an N-tick cycle from the `word_done` edge.
- R7: A later word is stored in a shadow copy. It is applied at the first main terminal count at which `cp_busy` is low. That reload uses the new N and clears the accumulator. The new reference ratio takes effect at the reference counter's next reload.
- R8: While `cp_busy` is high at every main terminal count, the active word does not change and the old ratios continue.
- R9: A second word written before the shadow copy has been applied replaces the pending one, and only the later word takes effect.
- R10: `mon_ref` and `mon_main` are high in exactly the clocks where `ref_pulse` and `main_pulse` are high, provided `test_en` was high at the edge that produced the pulse. Otherwise they are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One reference tick per high cycle |
| rf_en | input | 1 | One RF-derived tick per high cycle |
| sf_word | input | SF_W | Scaling word 4·N+k |
| ref_sel | input | 2 | Reference ratio code |
| word_done | input | 1 | Write of `sf_word`/`ref_sel` complete (single cycle) |
| cp_busy | input | 1 | Charge pump currently sourcing or sinking |
| test_en | input | 1 | Route divider pulses to monitor taps |
| ref_pulse | output | 1 | Divided reference pulse |
| main_pulse | output | 1 | Divided RF pulse |
| mon_ref | output | 1 | Monitor tap of the reference divider |
| mon_main | output | 1 | Monitor tap of the main divider |

## Verification
The bench builds the block with SF_W = 7, SF_MIN = 8 and reference ratios 5, 6, 4 and 7. With these values, every fractional pattern for k = 0 to 3 repeats within a few dozen clocks. All four reference codes can be measured directly, and the floor clamp is reachable with 7-bit words below 8. A long stretch of irregular enables, busy intervals and overlapping writes is compared clock by clock against a behavioural model. This stretch brings shadow overwrites, writes that coincide with terminal counts, and commits postponed by busy within reach.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  typedef enum logic [1:0] {
    RSEL_A = 2'd0,
    RSEL_B = 2'd1,
    RSEL_C = 2'd2,
    RSEL_D = 2'd3
  } refsel_e;

  function automatic int unsigned pick_ratio(input logic [1:0] s,
                                             input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c,
                                             input int unsigned d);
    case (refsel_e'(s))
      RSEL_A:  return a;
      RSEL_B:  return b;
      RSEL_C:  return c;
      default: return d;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c,
                                       input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fracn_rst_sync.sv
module fracn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  // asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fracn_cfg_ctrl.sv
module fracn_cfg_ctrl #(
  parameter int SF_W   = 15,
  parameter int SF_MIN = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_done,
  input  logic [SF_W-1:0] sf_word,
  input  logic [1:0]      ref_sel,
  input  logic            cp_busy,
  input  logic            main_tc,
  output logic            armed,
  output logic            start,
  output logic            commit,
  output logic [SF_W-1:0] act_word,
  output logic [1:0]      act_sel,
  output logic [SF_W-3:0] load_n,
  output logic [1:0]      ref_ld_sel
);
  localparam logic [SF_W-1:0] FLOOR = SF_W'(SF_MIN);

  logic [SF_W-1:0] in_word;
  logic            armed_nx;
  logic            pend_q, pend_nx;
  logic [SF_W-1:0] sh_word_q, sh_word_nx;
  logic [1:0]      sh_sel_q, sh_sel_nx;
  logic [SF_W-1:0] act_word_nx;
  logic [1:0]      act_sel_nx;
  logic            capture;

  // floor clamp on the incoming word
  always_comb begin
    in_word = (sf_word < FLOOR) ? FLOOR : sf_word;
  end

  always_comb begin
    start      = word_done & ~armed;
    capture    = word_done & armed;
    commit     = main_tc & pend_q & ~cp_busy;
    load_n     = start ? in_word[SF_W-1:2] : sh_word_q[SF_W-1:2];
    ref_ld_sel = start ? ref_sel : act_sel;
  end

  // next state: first word goes live directly, later ones wait in the shadow
  always_comb begin
    armed_nx    = armed;
    pend_nx     = pend_q;
    sh_word_nx  = sh_word_q;
    sh_sel_nx   = sh_sel_q;
    act_word_nx = act_word;
    act_sel_nx  = act_sel;
    if (start) begin
      armed_nx    = 1'b1;
      act_word_nx = in_word;
      act_sel_nx  = ref_sel;
    end
    if (commit) begin
      act_word_nx = sh_word_q;
      act_sel_nx  = sh_sel_q;
      pend_nx     = 1'b0;
    end
    if (capture) begin
      sh_word_nx = in_word;
      sh_sel_nx  = ref_sel;
      pend_nx    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      pend_q    <= 1'b0;
      sh_word_q <= '0;
      sh_sel_q  <= '0;
      act_word  <= '0;
      act_sel   <= '0;
    end else begin
      armed     <= armed_nx;
      pend_q    <= pend_nx;
      sh_word_q <= sh_word_nx;
      sh_sel_q  <= sh_sel_nx;
      act_word  <= act_word_nx;
      act_sel   <= act_sel_nx;
    end
  end
endmodule

// File: rtl/fracn_ref_div.sv
module fracn_ref_div
  import fracn_pkg::*;
#(
  parameter int unsigned REF_A = 280,
  parameter int unsigned REF_B = 288,
  parameter int unsigned REF_C = 256,
  parameter int unsigned REF_D = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       armed,
  input  logic       start,
  input  logic [1:0] sel,
  output logic       tc,
  output logic       pulse
);
  localparam int unsigned REF_MAX = max4(REF_A, REF_B, REF_C, REF_D);
  localparam int RC_W = (REF_MAX > 2) ? $clog2(REF_MAX) : 1;

  logic [RC_W-1:0] cnt_q, cnt_nx, reload;
  logic            pulse_nx;

  always_comb begin
    reload = RC_W'(pick_ratio(sel, REF_A, REF_B, REF_C, REF_D) - 1);
    tc     = armed & tick & (cnt_q == '0);
  end

  // down counter, reload at zero; held while not armed
  always_comb begin
    cnt_nx   = cnt_q;
    pulse_nx = tc;
    if (start) begin
      cnt_nx = reload;
    end else if (armed && tick) begin
      if (cnt_q == '0) cnt_nx = reload;
      else             cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      pulse <= pulse_nx;
    end
  end
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div #(
  parameter int SF_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            armed,
  input  logic            start,
  input  logic            commit,
  input  logic [SF_W-1:0] act_word,
  input  logic [SF_W-3:0] load_n,
  output logic            tc,
  output logic            pulse
);
  localparam int N_W  = SF_W - 2;
  localparam int MC_W = N_W + 1;

  logic [MC_W-1:0] cnt_q, cnt_nx;
  logic [1:0]      acc_q, acc_nx;
  logic [2:0]      acc_sum;
  logic [MC_W-1:0] len_act, len_load;
  logic            pulse_nx;

  always_comb begin
    tc       = armed & tick & (cnt_q == '0);
    acc_sum  = {1'b0, acc_q} + {1'b0, act_word[1:0]};
    // carry out of the accumulator stretches the next cycle by one tick
    len_act  = MC_W'({1'b0, act_word[SF_W-1:2]}) + MC_W'(acc_sum[2]) - MC_W'(1);
    len_load = MC_W'({1'b0, load_n}) - MC_W'(1);
  end

  always_comb begin
    cnt_nx   = cnt_q;
    acc_nx   = acc_q;
    pulse_nx = tc;
    if (start) begin
      cnt_nx = len_load;
      acc_nx = '0;
    end else if (armed && tick) begin
      if (cnt_q == '0) begin
        if (commit) begin
          cnt_nx = len_load;
          acc_nx = '0;
        end else begin
          cnt_nx = len_act;
          acc_nx = acc_sum[1:0];
        end
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      acc_q <= acc_nx;
      pulse <= pulse_nx;
    end
  end
endmodule

// File: rtl/fracn_divcore.sv
module fracn_divcore #(
  parameter int          SF_W   = 15,
  parameter int          SF_MIN = 2048,
  parameter int unsigned REF_A  = 280,
  parameter int unsigned REF_B  = 288,
  parameter int unsigned REF_C  = 256,
  parameter int unsigned REF_D  = 384
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_en,
  input  logic            rf_en,
  input  logic [SF_W-1:0] sf_word,
  input  logic [1:0]      ref_sel,
  input  logic            word_done,
  input  logic            cp_busy,
  input  logic            test_en,
  output logic            ref_pulse,
  output logic            main_pulse,
  output logic            mon_ref,
  output logic            mon_main
);
  localparam int N_TAPS = 2;

  logic            rst_core_n;
  logic            armed, start, commit;
  logic            ref_tc, main_tc;
  logic [SF_W-1:0] act_word;
  logic [1:0]      act_sel;
  logic [SF_W-3:0] load_n;
  logic [1:0]      ref_ld_sel;
  logic [N_TAPS-1:0] tap_src, tap_q;

  fracn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_core_n)
  );

  fracn_cfg_ctrl #(.SF_W(SF_W), .SF_MIN(SF_MIN)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .word_done  (word_done),
    .sf_word    (sf_word),
    .ref_sel    (ref_sel),
    .cp_busy    (cp_busy),
    .main_tc    (main_tc),
    .armed      (armed),
    .start      (start),
    .commit     (commit),
    .act_word   (act_word),
    .act_sel    (act_sel),
    .load_n     (load_n),
    .ref_ld_sel (ref_ld_sel)
  );

  fracn_ref_div #(.REF_A(REF_A), .REF_B(REF_B), .REF_C(REF_C), .REF_D(REF_D)) u_ref (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (ref_en),
    .armed (armed),
    .start (start),
    .sel   (ref_ld_sel),
    .tc    (ref_tc),
    .pulse (ref_pulse)
  );

  fracn_main_div #(.SF_W(SF_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (rf_en),
    .armed    (armed),
    .start    (start),
    .commit   (commit),
    .act_word (act_word),
    .load_n   (load_n),
    .tc       (main_tc),
    .pulse    (main_pulse)
  );

  // monitor taps: one gated flop per divider
  assign tap_src = {main_tc, ref_tc};

  for (genvar gi = 0; gi < N_TAPS; gi++) begin : g_tap
    logic q, q_nx;
    always_comb q_nx = test_en & tap_src[gi];
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) q <= 1'b0;
      else             q <= q_nx;
    end
    assign tap_q[gi] = q;
  end

  assign mon_ref  = tap_q[0];
  assign mon_main = tap_q[1];
endmodule

// File: rtl/fracn_divcore_chk.sv
module fracn_divcore_chk #(
  parameter int SF_W   = 15,
  parameter int SF_MIN = 2048
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_en,
  input logic            rf_en,
  input logic            word_done,
  input logic            cp_busy,
  input logic            test_en,
  input logic            ref_pulse,
  input logic            main_pulse,
  input logic            mon_ref,
  input logic            mon_main,
  input logic            armed,
  input logic [SF_W-1:0] act_word
);
  logic seen_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_word <= 1'b0;
    else if (word_done) seen_word <= 1'b1;
  end

  a_r1_quiet_until_word: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_word |-> (!ref_pulse && !main_pulse && !mon_ref && !mon_main));

  a_r4_floor_held: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (act_word >= SF_W'(SF_MIN)));

  a_r5_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  a_r5_main_single: assert property (@(posedge clk) disable iff (!rst_n)
    main_pulse |=> !main_pulse);

  a_r5_ref_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_en));

  a_r5_main_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    main_pulse |-> $past(rf_en));

  a_r8_busy_freezes_word: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cp_busy) |=> $stable(act_word));

  a_r10_mon_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mon_ref == (ref_pulse && $past(test_en)));

  a_r10_mon_main: assert property (@(posedge clk) disable iff (!rst_n)
    mon_main == (main_pulse && $past(test_en)));
endmodule

bind fracn_divcore fracn_divcore_chk #(.SF_W(SF_W), .SF_MIN(SF_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_en     (ref_en),
  .rf_en      (rf_en),
  .word_done  (word_done),
  .cp_busy    (cp_busy),
  .test_en    (test_en),
  .ref_pulse  (ref_pulse),
  .main_pulse (main_pulse),
  .mon_ref    (mon_ref),
  .mon_main   (mon_main),
  .armed      (armed),
  .act_word   (act_word)
);

// File: tb/fracn_divcore_bench.sv
module fracn_divcore_bench;
  localparam int SFW = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ref_en, rf_en, word_done, cp_busy, test_en;
  logic [SFW-1:0] sf_word;
  logic [1:0]     ref_sel;
  logic           ref_pulse, main_pulse, mon_ref, mon_main;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit cmp_on   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fracn_divcore #(.SF_W(SFW), .SF_MIN(8), .REF_A(5), .REF_B(6), .REF_C(4), .REF_D(7))
  u_fracn_divcore (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rf_en(rf_en), .sf_word(sf_word),
    .ref_sel(ref_sel), .word_done(word_done), .cp_busy(cp_busy), .test_en(test_en),
    .ref_pulse(ref_pulse), .main_pulse(main_pulse), .mon_ref(mon_ref), .mon_main(mon_main)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rat(input int s);
    case (s)
      0: return 5;
      1: return 6;
      2: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic int clampw(input int w);
    return (w < 8) ? 8 : w;
  endfunction

  // behavioural reference model, advanced on every rising edge
  int m_armed, m_pend, m_sh, m_shsel, m_act, m_actsel, m_acc, m_rc, m_mc;
  bit e_ref, e_main, e_mref, e_mmain;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit rtc, mtc, com;
    int sum;
    if (!rst_n) begin
      m_armed = 0; m_pend = 0; m_sh = 0; m_shsel = 0; m_act = 0; m_actsel = 0;
      m_acc = 0; m_rc = 0; m_mc = 0;
      e_ref = 0; e_main = 0; e_mref = 0; e_mmain = 0;
    end else begin
      rtc = (m_armed != 0) && ref_en && (m_rc == 0);
      mtc = (m_armed != 0) && rf_en && (m_mc == 0);
      com = mtc && (m_pend != 0) && !cp_busy;
      e_ref = rtc; e_main = mtc;
      e_mref = test_en && rtc; e_mmain = test_en && mtc;
      if (m_armed == 0) begin
        if (word_done) begin
          m_armed = 1; m_act = clampw(int'(sf_word)); m_actsel = int'(ref_sel);
          m_rc = rat(m_actsel) - 1; m_mc = m_act / 4 - 1; m_acc = 0;
        end
      end else begin
        if (ref_en) m_rc = (m_rc == 0) ? rat(m_actsel) - 1 : m_rc - 1;
        if (rf_en) begin
          if (m_mc == 0) begin
            if (com) begin
              m_mc = m_sh / 4 - 1; m_acc = 0;
            end else begin
              sum = m_acc + (m_act % 4);
              m_acc = sum % 4;
              m_mc = m_act / 4 + ((sum >= 4) ? 1 : 0) - 1;
            end
          end else m_mc = m_mc - 1;
        end
        if (com) begin m_act = m_sh; m_actsel = m_shsel; m_pend = 0; end
        if (word_done) begin m_sh = clampw(int'(sf_word)); m_shsel = int'(ref_sel); m_pend = 1; end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check_eq("R2", "ref_pulse vs model", int'(ref_pulse), int'(e_ref));
      check_eq("R3", "main_pulse vs model", int'(main_pulse), int'(e_main));
      check_eq("R10", "mon_ref vs model", int'(mon_ref), int'(e_mref));
      check_eq("R10", "mon_main vs model", int'(mon_main), int'(e_mmain));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog (R1 to R10 run incomplete): actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic write_word(input int sf, input int sel);
    @(negedge clk);
    sf_word = SFW'(sf); ref_sel = 2'(sel); word_done = 1'b1;
    @(negedge clk);
    word_done = 1'b0;
  endtask

  task automatic wait_main();
    do @(negedge clk); while (!main_pulse);
  endtask

  task automatic wait_ref();
    do @(negedge clk); while (!ref_pulse);
  endtask

  task automatic main_gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!main_pulse);
  endtask

  task automatic ref_gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!ref_pulse);
  endtask

  task automatic check_windows(input int sf, input string req);
    int g [8];
    int s;
    wait_main();
    for (int i = 0; i < 8; i++) main_gap(g[i]);
    for (int i = 0; i < 5; i++) begin
      s = g[i] + g[i+1] + g[i+2] + g[i+3];
      check_eq(req, $sformatf("four-cycle span sf=%0d", sf), s, clampw(sf));
    end
  endtask

  task automatic check_gaps(input int n, input int exp, input string req);
    int g;
    wait_main();
    for (int i = 0; i < n; i++) begin
      main_gap(g);
      check_eq(req, "main cycle length", g, exp);
    end
  endtask

  initial begin
    int fr, fm, g;
    rst_n = 1'b0; ref_en = 1'b1; rf_en = 1'b1; word_done = 1'b0;
    cp_busy = 1'b0; test_en = 1'b0; sf_word = '0; ref_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1: quiet until first word
    check_eq("R1", "ref_pulse after reset", int'(ref_pulse), 0);
    check_eq("R1", "main_pulse after reset", int'(main_pulse), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_eq("R1", "no pulse before word", int'(ref_pulse | main_pulse | mon_ref | mon_main), 0);
    end

    // R6: first word loads at once (N=3,k=1, ratio 5)
    @(negedge clk);
    sf_word = SFW'(13); ref_sel = 2'd0; word_done = 1'b1;
    @(negedge clk);
    word_done = 1'b0;
    fr = 0; fm = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (ref_pulse && fr == 0) fr = c;
      if (main_pulse && fm == 0) begin
        fm = c;
        @(negedge clk);
        c++;
        // R5: one clock wide
        check_eq("R5", "main pulse width", int'(main_pulse), 0);
        if (ref_pulse && fr == 0) fr = c;
      end
    end
    check_eq("R6", "first ref pulse delay", fr, 5);
    check_eq("R6", "first main pulse delay", fm, 3);

    // R3: fractional patterns k = 0..3
    for (int k = 0; k < 4; k++) begin
      write_word(12 + k, 0);
      repeat (2) wait_main();
      check_windows(12 + k, "R3");
    end

    // R2: each reference code
    for (int s = 0; s < 4; s++) begin
      write_word(12, s);
      wait_main();
      repeat (3) wait_ref();
      for (int i = 0; i < 3; i++) begin
        ref_gap(g);
        check_eq("R2", $sformatf("ref cycle code %0d", s), g, rat(s));
      end
    end

    // R4: words below the floor
    write_word(3, 0);
    repeat (2) wait_main();
    check_gaps(4, 2, "R4");
    write_word(9, 0);
    repeat (2) wait_main();
    check_windows(9, "R4");

    // R7: shadow applied at next terminal count, new N immediately
    write_word(12, 0);
    repeat (3) wait_main();
    write_word(16, 0);
    wait_main();
    main_gap(g);
    check_eq("R7", "first cycle after commit", g, 4);

    // R8: busy blocks the commit
    cp_busy = 1'b1;
    write_word(24, 0);
    check_gaps(4, 4, "R8");
    cp_busy = 1'b0;
    repeat (2) wait_main();
    check_gaps(3, 6, "R7");

    // R9: later pending word wins
    cp_busy = 1'b1;
    write_word(28, 0);
    write_word(32, 0);
    check_gaps(3, 6, "R8");
    cp_busy = 1'b0;
    repeat (2) wait_main();
    check_gaps(3, 8, "R9");

    // R10: monitor taps
    test_en = 1'b1;
    wait_main();
    check_eq("R10", "mon_main with test on", int'(mon_main), 1);
    wait_ref();
    check_eq("R10", "mon_ref with test on", int'(mon_ref), 1);
    test_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_eq("R10", "taps low with test off", int'(mon_ref | mon_main), 0);
    end

    // irregular traffic, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rf_en     = ($urandom_range(0, 3) != 0);
      ref_en    = ($urandom_range(0, 2) == 0);
      cp_busy   = ($urandom_range(0, 3) == 0);
      test_en   = 1'($urandom_range(0, 1));
      word_done = ($urandom_range(0, 60) == 0);
      if (word_done) begin
        sf_word = SFW'($urandom_range(0, 127));
        ref_sel = 2'($urandom_range(0, 3));
      end
    end
    @(negedge clk);
    word_done = 1'b0;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule